// File: doc/BRIEF.md
# Shadowed SRAM with Store and Recall

This block is a byte-wide static memory with a second, shadow copy that stands in for a nonvolatile array. On the ordinary port, the memory is read and written with active-low chip enable, write enable and output enable strobes. A command detector outside the block raises single-cycle pulses that either save the whole memory into the shadow array (store) or load the shadow array back into the memory (recall).

A store always has two phases. First comes an erase phase, which lasts a parameterised number of cycles. Then comes a program phase, which copies one location per clock. A recall copies one location per clock. While either operation runs, the port is locked out and a busy flag is high. A digital supply-good input guards the store in two ways. A store request is ignored while the supply is bad, and a running store is abandoned when the supply drops. An abandoned store sets a sticky error flag.

Top module: `nvshadow_sram`

## Requirements
- R1: While reset is held and after it is released, `busy`, `rd_en` and `store_err` are low.
- R2: When the block is idle and `ce_n`, `we_n` are low at a clock edge, `wdata` is written at `addr`. When the block is idle and `ce_n`, `oe_n` are low with `we_n` high at a clock edge, `rdata` holds the byte at `addr` and `rd_en` is high after that edge.
- R3: `rd_en` is high only after an edge that saw an accepted read. A low `we_n` turns the drivers off, even when `oe_n` is low.
- R4: When the block is idle and a store request arrives with `pwr_ok` high, `busy` is high for exactly ERASE_CYC plus 2^ADDR_W cycles, starting in the cycle after the request. After that, the shadow array holds the memory contents as they stood during the store.
- R5: When the block is idle, a recall request raises `busy` for exactly 2^ADDR_W cycles. After that, every memory location equals its shadow location.
- R6: While `busy` is high, port writes are discarded and port reads leave `rd_en` low.
- R7: A store request while `pwr_ok` is low starts nothing: `busy` stays low.
- R8: If `pwr_ok` drops during the program phase, the block is idle after the next edge and `store_err` rises. `store_err` stays high until reset. Shadow locations below the abort point hold the new data. All other locations read as all ones (8'hFF for byte width), the erased value.
- R9: If `pwr_ok` drops during the erase phase, the store stops, `store_err` rises, and the shadow array keeps its previous contents.
- R10: A store request wins over a recall request in the same cycle. Requests of either kind are ignored while `busy` is high.
- R11: Once an operation completes, the port reads and writes normally again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Port address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid when rd_en is high |
| rd_en | output | 1 | Output drivers on |
| store_req | input | 1 | Store request pulse |
| recall_req | input | 1 | Recall request pulse |
| pwr_ok | input | 1 | Supply-good indication |
| busy | output | 1 | Store or recall in progress |
| store_err | output | 1 | Sticky: a store was aborted |

## Verification
The port is swept exhaustively on a 16-location configuration with two address-derived data patterns. This shows that every address decodes to its own location and that no write aliases onto another. A full store is followed by overwriting the memory and then recalling. Because the overwritten data differs from the stored data, the read-back shows whether the data came from the shadow array or stayed from the port.

Aborts are injected at a known program index and inside the erase phase. The first case tests the split between programmed and erased shadow locations at one exact boundary. The second tests that the old shadow contents survive an abandoned erase. Port accesses and extra requests issued while busy are checked for having no effect, both on the busy length and on the read-back contents.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ERASE  = 2'd1,
    ST_PROG   = 2'd2,
    ST_RECALL = 2'd3
  } eng_state_t;
endpackage

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int ERASE_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_req,
  input  logic              recall_req,
  input  logic              pwr_ok,
  output logic              busy,
  output logic              storing,
  output logic              err,
  output logic [ADDR_W-1:0] idx,
  output logic              last,
  output logic              shd_wr,
  output logic              cp_wr,
  output logic              erase_commit
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int EC_W  = $clog2(ERASE_CYC + 1);
  localparam logic [EC_W-1:0]   EC_LAST  = EC_W'(ERASE_CYC - 1);
  localparam logic [ADDR_W-1:0] IDX_LAST = ADDR_W'(DEPTH - 1);

  eng_state_t        state, state_d;
  logic [ADDR_W-1:0] idx_d;
  logic [EC_W-1:0]   ecnt, ecnt_d;
  logic              err_d;

  assign busy    = (state != ST_IDLE);
  assign storing = (state == ST_ERASE) || (state == ST_PROG);
  assign last    = (idx == IDX_LAST);

  always_comb begin
    state_d      = state;
    idx_d        = idx;
    ecnt_d       = ecnt;
    err_d        = err;
    shd_wr       = 1'b0;
    cp_wr        = 1'b0;
    erase_commit = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (store_req && pwr_ok) begin
          state_d = ST_ERASE;
          ecnt_d  = '0;
        end else if (recall_req) begin
          state_d = ST_RECALL;
          idx_d   = '0;
        end
      end
      ST_ERASE: begin
        if (!pwr_ok) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else if (ecnt == EC_LAST) begin
          state_d      = ST_PROG;
          idx_d        = '0;
          erase_commit = 1'b1;
        end else begin
          ecnt_d = ecnt + 1'b1;
        end
      end
      ST_PROG: begin
        if (!pwr_ok) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else begin
          shd_wr = 1'b1;
          if (last) state_d = ST_IDLE;
          else      idx_d   = idx + 1'b1;
        end
      end
      ST_RECALL: begin
        cp_wr = 1'b1;
        if (last) state_d = ST_IDLE;
        else      idx_d   = idx + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      ecnt  <= '0;
      err   <= 1'b0;
    end else begin
      state <= state_d;
      idx   <= idx_d;
      ecnt  <= ecnt_d;
      err   <= err_d;
    end
  end
endmodule

// File: rtl/nvs_sram.sv
module nvs_sram #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_rd,
  input  logic              port_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cp_wr,
  input  logic [ADDR_W-1:0] cp_idx,
  input  logic [DATA_W-1:0] cp_data,
  output logic [DATA_W-1:0] arr_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_en
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  assign arr_q = mem[cp_idx];

  always_ff @(posedge clk) begin
    if (cp_wr)        mem[cp_idx] <= cp_data;
    else if (port_wr) mem[addr]   <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      rd_en <= 1'b0;
    end else begin
      rd_en <= port_rd;
      if (port_rd) rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/nvs_shadow.sv
module nvs_shadow #(
  parameter int          ADDR_W     = 13,
  parameter int          DATA_W     = 8,
  parameter logic [DATA_W-1:0] ERASED_VAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              erase_commit,
  input  logic              last,
  input  logic [ADDR_W-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wiped;
  logic [ADDR_W:0]   fill;

  assign rdata = (wiped && ({1'b0, idx} >= fill)) ? ERASED_VAL : mem[idx];

  always_ff @(posedge clk) begin
    if (wr) mem[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiped <= 1'b0;
      fill  <= '0;
    end else if (erase_commit) begin
      wiped <= 1'b1;
      fill  <= '0;
    end else if (wr) begin
      fill <= {1'b0, idx} + 1'b1;
      if (last) wiped <= 1'b0;
    end
  end
endmodule

// File: rtl/nvshadow_sram.sv
module nvshadow_sram #(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int ERASE_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_en,
  input  logic              store_req,
  input  logic              recall_req,
  input  logic              pwr_ok,
  output logic              busy,
  output logic              store_err
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              storing, last, shd_wr, cp_wr, erase_commit;
  logic              port_rd, port_wr;
  logic [ADDR_W-1:0] idx;
  logic [DATA_W-1:0] sram_q, shd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign port_rd = !busy && !ce_n && !oe_n && we_n;
  assign port_wr = !busy && !ce_n && !we_n;

  nvs_ctrl #(.ADDR_W(ADDR_W), .ERASE_CYC(ERASE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .store_req(store_req),
    .recall_req(recall_req), .pwr_ok(pwr_ok), .busy(busy),
    .storing(storing), .err(store_err), .idx(idx), .last(last),
    .shd_wr(shd_wr), .cp_wr(cp_wr), .erase_commit(erase_commit)
  );

  nvs_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sram (
    .clk(clk), .rst_n(rst_sync_n), .port_rd(port_rd), .port_wr(port_wr),
    .addr(addr), .wdata(wdata), .cp_wr(cp_wr), .cp_idx(idx),
    .cp_data(shd_q), .arr_q(sram_q), .rdata(rdata), .rd_en(rd_en)
  );

  nvs_shadow #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
    .clk(clk), .rst_n(rst_sync_n), .wr(shd_wr),
    .erase_commit(erase_commit), .last(last), .idx(idx),
    .wdata(sram_q), .rdata(shd_q)
  );
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic we_n,
  input logic oe_n,
  input logic busy,
  input logic rd_en,
  input logic store_err,
  input logic store_req,
  input logic recall_req,
  input logic pwr_ok,
  input logic storing
);
  p_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ce_n && !oe_n && we_n) |=> rd_en);
  p_wr_drv_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> !rd_en);
  p_store_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && store_req && pwr_ok) |=> busy);
  p_lockout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rd_en);
  p_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && store_req && !pwr_ok && !recall_req) |=> !busy);
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (storing && !pwr_ok) |=> (!busy && store_err));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    store_err |=> store_err);
endmodule

bind nvshadow_sram nvs_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .busy(busy), .rd_en(rd_en), .store_err(store_err), .store_req(store_req),
  .recall_req(recall_req), .pwr_ok(pwr_ok), .storing(storing)
);

// File: tb/sim_nvshadow_sram.sv
module sim_nvshadow_sram;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int EC = 3;
  localparam int N  = 1 << AW;

  logic          clk, rst_n, ce_n, we_n, oe_n, store_req, recall_req, pwr_ok;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          rd_en, busy, store_err;
  int            errors = 0, checks = 0, cyc = 0;
  logic [DW-1:0] exp_shd [N];

  nvshadow_sram #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYC(EC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_en(rd_en),
    .store_req(store_req), .recall_req(recall_req), .pwr_ok(pwr_ok),
    .busy(busy), .store_err(store_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic logic [DW-1:0] pat(input int a, input int seed);
    return DW'((a * 13 + seed * 5 + 1) & 8'h7F);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    ce_n = 0; we_n = 0; oe_n = 1; addr = AW'(a); wdata = d;
    @(negedge clk);
    ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d, output logic en);
    ce_n = 0; we_n = 1; oe_n = 0; addr = AW'(a);
    @(negedge clk);
    d = rdata; en = rd_en;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic fill_mem(input int seed);
    for (int a = 0; a < N; a++) wr(a, pat(a, seed));
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n = n + 1;
      @(negedge clk);
    end
  endtask

  task automatic pulse(input logic s, input logic r);
    store_req = s; recall_req = r;
    @(negedge clk);
    store_req = 0; recall_req = 0;
  endtask

  initial begin
    logic [DW-1:0] d;
    logic          en;
    int            n, bad;
    rst_n = 0; ce_n = 1; we_n = 1; oe_n = 1; addr = '0; wdata = '0;
    store_req = 0; recall_req = 0; pwr_ok = 1;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 rd_en in reset", rd_en, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 store_err after reset", store_err, 0);
    chk("R1 rd_en after reset", rd_en, 0);

    // R2 exhaustive sweep, two patterns
    for (int s = 0; s < 2; s++) begin
      fill_mem(s + 1);
      bad = 0;
      for (int a = 0; a < N; a++) begin
        rd(a, d, en);
        if (d !== pat(a, s + 1) || en !== 1'b1) bad = bad + 1;
      end
      chk("R2 sweep mismatches", bad, 0);
    end

    // R3 write with oe_n low: drivers off; idle cycle: drivers off
    ce_n = 0; we_n = 0; oe_n = 0; addr = 4'd2; wdata = 8'h3C;
    @(negedge clk);
    chk("R3 rd_en with we_n low", rd_en, 0);
    ce_n = 1; we_n = 1; oe_n = 1;
    @(negedge clk);
    chk("R3 rd_en when deselected", rd_en, 0);
    rd(2, d, en);
    chk("R2 write with oe_n low stored", d, 8'h3C);

    // R4 full store
    fill_mem(3);
    for (int a = 0; a < N; a++) exp_shd[a] = pat(a, 3);
    pulse(1, 0);
    count_busy(n);
    chk("R4 store busy length", n, EC + N);
    chk("R4 no error", store_err, 0);

    // R5 recall after overwrite
    fill_mem(4);
    pulse(0, 1);
    count_busy(n);
    chk("R5 recall busy length", n, N);
    bad = 0;
    for (int a = 0; a < N; a++) begin
      rd(a, d, en);
      if (d !== exp_shd[a]) bad = bad + 1;
    end
    chk("R5 R11 recalled contents", bad, 0);

    // R6 R10: lockout and ignored requests during recall
    fill_mem(5);
    pulse(0, 1);
    ce_n = 0; we_n = 0; addr = 4'd5; wdata = 8'hEE; store_req = 1;
    @(negedge clk);
    ce_n = 0; we_n = 1; oe_n = 0; store_req = 0;
    @(negedge clk);
    chk("R6 rd_en after read while busy", rd_en, 0);
    ce_n = 1; oe_n = 1;
    count_busy(n);
    chk("R10 recall length with store req inside", n, N - 2);
    rd(5, d, en);
    chk("R6 write while busy discarded", d, exp_shd[5]);
    chk("R10 store req while busy no error", store_err, 0);

    // R7 store refused with supply low
    fill_mem(6);
    pwr_ok = 0;
    pulse(1, 0);
    chk("R7 busy after refused store", busy, 0);
    pwr_ok = 1;
    @(negedge clk);
    chk("R7 no error", store_err, 0);

    // R10 simultaneous requests: store wins
    pulse(1, 1);
    count_busy(n);
    chk("R10 store priority length", n, EC + N);
    for (int a = 0; a < N; a++) exp_shd[a] = pat(a, 6);

    // R9 abort inside erase
    fill_mem(7);
    pulse(1, 0);
    @(negedge clk);
    pwr_ok = 0;
    @(negedge clk);
    chk("R9 idle after erase abort", busy, 0);
    chk("R9 error raised", store_err, 1);
    pwr_ok = 1;
    fill_mem(8);
    pulse(0, 1);
    count_busy(n);
    bad = 0;
    for (int a = 0; a < N; a++) begin
      rd(a, d, en);
      if (d !== exp_shd[a]) bad = bad + 1;
    end
    chk("R9 shadow kept after erase abort", bad, 0);

    // R8 abort inside program at index 6
    fill_mem(9);
    pulse(1, 0);
    repeat (EC + 6) @(negedge clk);
    pwr_ok = 0;
    @(negedge clk);
    chk("R8 idle after program abort", busy, 0);
    chk("R8 error sticky", store_err, 1);
    pwr_ok = 1;
    fill_mem(10);
    pulse(0, 1);
    count_busy(n);
    bad = 0;
    for (int a = 0; a < N; a++) begin
      rd(a, d, en);
      if (d !== ((a < 6) ? pat(a, 9) : 8'hFF)) bad = bad + 1;
    end
    chk("R8 partial shadow split", bad, 0);
    chk("R8 error still set", store_err, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule